// File: doc/BRIEF.md
# Receive Header Split Decision Unit

This unit sits on the receive path of a network controller, between the frame parser and the receive DMA engine. For every received frame it decides whether the frame goes into two host buffers, a header buffer and a payload buffer, or stays whole in the payload buffer. When the frame is split, the unit also decides how many leading bytes land in the header buffer. It also produces the three header fields that are written back into the completed receive descriptor: the reported header length, the split-header flag and the header-overflow flag.

The decision uses three inputs. The first is the queue's receive control word, which holds the descriptor type and the header buffer size. The second is the total frame length. The third is what the parser found: the IP version present, the fragment flag, the transport protocol, and the byte offsets of the transport header and of the data after it. A global control bit can stop fragmented frames from being split by protocol. There are two split modes. A plain mode declines the split when the header cannot be located or does not fit. An "always" mode instead falls back to a fixed header of one full header buffer.

Every request arrives with a one-cycle valid strobe. The unit returns a registered result with a matching valid exactly one clock later.

Top module: `hs_split_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `split_en`, `hdr_bytes`, `wb_hdr_len`, `wb_sph` and `wb_hbo` to zero.
- R2: A request sampled with `in_valid` high produces its result, with `out_valid` high, on the next clock. On a clock without `in_valid`, `out_valid` goes low and the result outputs keep their previous values.
- R3: The descriptor type is `rx_ctrl[27:25]`. Only type 2 (plain split) and type 5 (split always) consider splitting. Every other type, such as 0, 1, 3 or 7, gives `split_en`, `hdr_bytes`, `wb_hdr_len`, `wb_sph` and `wb_hbo` all zero.
- R4: The header buffer size in bytes is `rx_ctrl[11:8]` times 64. All other bits of `rx_ctrl` outside 27:25 have no effect.
- R5: In split-always mode, a frame with `frame_len` no larger than the header buffer size is split with `hdr_bytes` = `wb_hdr_len` = `frame_len`, and `wb_sph` and `wb_hbo` both 0. This holds whatever the protocol inputs say.
- R6: In either split mode, a longer frame with neither `has_ipv4` nor `has_ipv6` is not handled by protocol. It reports `wb_hdr_len` = header buffer size, with `wb_sph` = 0 and `wb_hbo` = 0.
- R7: A fragmented IP frame with `frag_split_dis` = 1 is not handled by protocol, and reports the same way as in R6. With `frag_split_dis` = 0, a fragment is split at the transport header offset.
- R8: `l4_kind` is coded 0 = other, 1 = TCP, 2 = UDP, 3 = SCTP. A non-fragmented TCP or UDP frame uses `l5_ofs` as the split point. Every other IP frame uses `l4_ofs`. Once a split point is found, `wb_sph` = 1 and `wb_hdr_len` = the split point.
- R9: If the split point exceeds the header buffer size, `wb_hbo` = 1 and the frame counts as not handled. A split point equal to the buffer size still fits.
- R10: A frame that is not handled (R6, R7, R9) is split in split-always mode with `hdr_bytes` = header buffer size. In plain split mode it is not split, and `split_en` = 0 and `hdr_bytes` = 0.
- R11: Whenever `split_en` is 1, `hdr_bytes` is no larger than the header buffer size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, samples all request inputs |
| rx_ctrl | input | CTRL_W | Queue receive control word (type in 27:25, header size in 11:8) |
| frame_len | input | LEN_W | Total frame length in bytes |
| has_ipv4 | input | 1 | Parser found an IPv4 header |
| has_ipv6 | input | 1 | Parser found an IPv6 header |
| is_frag | input | 1 | Frame is an IP fragment |
| l4_kind | input | 2 | Transport protocol code (0 other, 1 TCP, 2 UDP, 3 SCTP) |
| l4_ofs | input | OFS_W | Byte offset of the transport header |
| l5_ofs | input | OFS_W | Byte offset of the data after the transport header |
| frag_split_dis | input | 1 | Global: do not split fragments by protocol |
| out_valid | output | 1 | Result valid, one clock after the request |
| split_en | output | 1 | Frame is split into header and payload buffers |
| hdr_bytes | output | HL_W | Bytes placed in the header buffer |
| wb_hdr_len | output | HL_W | Header length reported in the descriptor |
| wb_sph | output | 1 | Split-header flag reported in the descriptor |
| wb_hbo | output | 1 | Header-buffer-overflow flag reported in the descriptor |

## Verification
The bound checker runs on every cycle and checks the following:
- the one-clock valid timing and the output hold when no request arrives;
- that every type other than 2 and 5 gives all-zero results;
- that an overflow is always flagged together with the split-header flag;
- that plain split mode never splits on an overflow;
- that any split stays within the header buffer size of its request.

The bench's scenarios are needed for three things. The first is the exact header lengths chosen for each protocol and fragment combination. The second is the split-always fallback values. The third is the boundary cases where the frame length or the split point equals the buffer size, or the buffer size is zero. These depend on the request's parsed fields in ways that a cycle-local property cannot predict without repeating the decision.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Positions inside the per-queue receive control word
  localparam int DTYPE_LSB  = 25;
  localparam int DTYPE_W    = 3;
  localparam int HBSZ_LSB   = 8;
  localparam int HBSZ_W     = 4;
  localparam int HBSZ_SHIFT = 6;  // field counts 64-byte units

  localparam logic [DTYPE_W-1:0] DT_SPLIT        = 3'd2;
  localparam logic [DTYPE_W-1:0] DT_SPLIT_ALWAYS = 3'd5;

  typedef enum logic [1:0] {
    L4_OTHER = 2'd0,
    L4_TCP   = 2'd1,
    L4_UDP   = 2'd2,
    L4_SCTP  = 2'd3
  } l4_kind_e;
endpackage

// File: rtl/hs_ctrl_decode.sv
module hs_ctrl_decode
  import hs_pkg::*;
#(
  parameter int CTRL_W = 32,
  parameter int BSZ_W  = HBSZ_W + HBSZ_SHIFT
) (
  input  logic [CTRL_W-1:0] rx_ctrl,
  output logic              mode_split,
  output logic              mode_always,
  output logic [BSZ_W-1:0]  hbuf_size
);
  logic [DTYPE_W-1:0] dtype;
  logic [HBSZ_W-1:0]  hsz_field;

  assign dtype     = rx_ctrl[DTYPE_LSB +: DTYPE_W];
  assign hsz_field = rx_ctrl[HBSZ_LSB +: HBSZ_W];

  assign mode_always = (dtype == DT_SPLIT_ALWAYS);
  assign mode_split  = (dtype == DT_SPLIT) || mode_always;
  assign hbuf_size   = BSZ_W'({hsz_field, {HBSZ_SHIFT{1'b0}}});

  // Bits of the control word that play no part in the decision
  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{rx_ctrl[CTRL_W-1:DTYPE_LSB+DTYPE_W],
                              rx_ctrl[DTYPE_LSB-1:HBSZ_LSB+HBSZ_W],
                              rx_ctrl[HBSZ_LSB-1:0]};
endmodule

// File: rtl/hs_proto_point.sv
module hs_proto_point
  import hs_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             has_ipv4,
  input  logic             has_ipv6,
  input  logic             is_frag,
  input  l4_kind_e         l4_kind,
  input  logic [OFS_W-1:0] l4_ofs,
  input  logic [OFS_W-1:0] l5_ofs,
  input  logic             frag_split_dis,
  output logic             proto_ok,
  output logic [OFS_W-1:0] point_ofs
);
  logic is_ip;
  logic stream_or_dgram;
  logic past_l4;

  assign is_ip           = has_ipv4 | has_ipv6;
  assign proto_ok        = is_ip & ~(is_frag & frag_split_dis);
  assign stream_or_dgram = (l4_kind == L4_TCP) || (l4_kind == L4_UDP);
  assign past_l4         = ~is_frag & stream_or_dgram;
  assign point_ofs       = past_l4 ? l5_ofs : l4_ofs;
endmodule

// File: rtl/hs_split_select.sv
module hs_split_select #(
  parameter int LEN_W = 16,
  parameter int OFS_W = 10,
  parameter int BSZ_W = 10,
  parameter int HL_W  = 10
) (
  input  logic             mode_split,
  input  logic             mode_always,
  input  logic [BSZ_W-1:0] hbuf_size,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             proto_ok,
  input  logic [OFS_W-1:0] point_ofs,
  output logic             split_en,
  output logic [HL_W-1:0]  hdr_bytes,
  output logic [HL_W-1:0]  wb_hdr_len,
  output logic             wb_sph,
  output logic             wb_hbo
);
  localparam int CMP_A = (LEN_W > OFS_W) ? LEN_W : OFS_W;
  localparam int CMP_W = (CMP_A > BSZ_W) ? CMP_A : BSZ_W;

  logic [CMP_W-1:0] len_c, buf_c, ofs_c;
  logic             fits_whole;
  logic             point_over;
  logic             not_handled;

  assign len_c      = CMP_W'(frame_len);
  assign buf_c      = CMP_W'(hbuf_size);
  assign ofs_c      = CMP_W'(point_ofs);
  assign fits_whole = mode_always && (len_c <= buf_c);
  assign point_over = ofs_c > buf_c;

  always_comb begin
    split_en    = 1'b0;
    hdr_bytes   = '0;
    wb_hdr_len  = '0;
    wb_sph      = 1'b0;
    wb_hbo      = 1'b0;
    not_handled = 1'b0;
    if (mode_split) begin
      if (fits_whole) begin
        split_en   = 1'b1;
        hdr_bytes  = HL_W'(len_c);
        wb_hdr_len = HL_W'(len_c);
      end else if (!proto_ok) begin
        wb_hdr_len  = HL_W'(buf_c);
        not_handled = 1'b1;
      end else begin
        wb_sph     = 1'b1;
        wb_hdr_len = HL_W'(ofs_c);
        if (point_over) begin
          wb_hbo      = 1'b1;
          not_handled = 1'b1;
        end else begin
          split_en  = 1'b1;
          hdr_bytes = HL_W'(ofs_c);
        end
      end
      if (not_handled && mode_always) begin
        split_en  = 1'b1;
        hdr_bytes = HL_W'(buf_c);
      end
    end
  end
endmodule

// File: rtl/hs_split_unit.sv
module hs_split_unit
  import hs_pkg::*;
#(
  parameter int CTRL_W = 32,
  parameter int LEN_W  = 16,
  parameter int OFS_W  = 10,
  localparam int BSZ_W = HBSZ_W + HBSZ_SHIFT,
  localparam int HL_W  = (OFS_W > BSZ_W) ? OFS_W : BSZ_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CTRL_W-1:0] rx_ctrl,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              has_ipv4,
  input  logic              has_ipv6,
  input  logic              is_frag,
  input  logic [1:0]        l4_kind,
  input  logic [OFS_W-1:0]  l4_ofs,
  input  logic [OFS_W-1:0]  l5_ofs,
  input  logic              frag_split_dis,
  output logic              out_valid,
  output logic              split_en,
  output logic [HL_W-1:0]   hdr_bytes,
  output logic [HL_W-1:0]   wb_hdr_len,
  output logic              wb_sph,
  output logic              wb_hbo
);
  logic             mode_split, mode_always;
  logic [BSZ_W-1:0] hbuf_size;
  logic             proto_ok;
  logic [OFS_W-1:0] point_ofs;
  logic             n_split, n_sph, n_hbo;
  logic [HL_W-1:0]  n_hdr, n_wb;

  hs_ctrl_decode #(.CTRL_W(CTRL_W), .BSZ_W(BSZ_W)) u_dec (
    .rx_ctrl     (rx_ctrl),
    .mode_split  (mode_split),
    .mode_always (mode_always),
    .hbuf_size   (hbuf_size)
  );

  hs_proto_point #(.OFS_W(OFS_W)) u_pt (
    .has_ipv4       (has_ipv4),
    .has_ipv6       (has_ipv6),
    .is_frag        (is_frag),
    .l4_kind        (l4_kind_e'(l4_kind)),
    .l4_ofs         (l4_ofs),
    .l5_ofs         (l5_ofs),
    .frag_split_dis (frag_split_dis),
    .proto_ok       (proto_ok),
    .point_ofs      (point_ofs)
  );

  hs_split_select #(.LEN_W(LEN_W), .OFS_W(OFS_W), .BSZ_W(BSZ_W), .HL_W(HL_W)) u_sel (
    .mode_split  (mode_split),
    .mode_always (mode_always),
    .hbuf_size   (hbuf_size),
    .frame_len   (frame_len),
    .proto_ok    (proto_ok),
    .point_ofs   (point_ofs),
    .split_en    (n_split),
    .hdr_bytes   (n_hdr),
    .wb_hdr_len  (n_wb),
    .wb_sph      (n_sph),
    .wb_hbo      (n_hbo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      split_en   <= 1'b0;
      hdr_bytes  <= '0;
      wb_hdr_len <= '0;
      wb_sph     <= 1'b0;
      wb_hbo     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        split_en   <= n_split;
        hdr_bytes  <= n_hdr;
        wb_hdr_len <= n_wb;
        wb_sph     <= n_sph;
        wb_hbo     <= n_hbo;
      end
    end
  end
endmodule

// File: rtl/hs_split_checker.sv
module hs_split_checker #(
  parameter int CTRL_W = 32,
  parameter int HL_W   = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [CTRL_W-1:0] rx_ctrl,
  input logic              out_valid,
  input logic              split_en,
  input logic [HL_W-1:0]   hdr_bytes,
  input logic [HL_W-1:0]   wb_hdr_len,
  input logic              wb_sph,
  input logic              wb_hbo
);
  logic [2:0]      req_type;
  logic [HL_W-1:0] req_bsz;
  logic            req_split_mode;

  // Captured per request so the output cycle can be related to its inputs
  always_ff @(posedge clk) begin
    if (rst) begin
      req_type <= '0;
      req_bsz  <= '0;
    end else if (in_valid) begin
      req_type <= rx_ctrl[27:25];
      req_bsz  <= HL_W'({rx_ctrl[11:8], 6'b0});
    end
  end
  assign req_split_mode = (req_type == 3'd2) || (req_type == 3'd5);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !split_en && hdr_bytes == '0 &&
                    wb_hdr_len == '0 && !wb_sph && !wb_hbo));

  a_r2_valid_next: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(split_en) && $stable(hdr_bytes) &&
                   $stable(wb_hdr_len) && $stable(wb_sph) && $stable(wb_hbo)));

  a_r3_other_type_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !req_split_mode) |->
      (!split_en && hdr_bytes == '0 && wb_hdr_len == '0 && !wb_sph && !wb_hbo));

  a_r9_hbo_with_sph: assert property (@(posedge clk) disable iff (rst)
    wb_hbo |-> wb_sph);

  a_r10_plain_overflow_no_split: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wb_hbo && req_type == 3'd2) |-> (!split_en && hdr_bytes == '0));

  a_r8_plain_split_marked: assert property (@(posedge clk) disable iff (rst)
    (out_valid && split_en && req_type == 3'd2) |-> (wb_sph && wb_hdr_len == hdr_bytes));

  a_r11_hdr_within_buf: assert property (@(posedge clk) disable iff (rst)
    (out_valid && split_en) |-> (hdr_bytes <= req_bsz));
endmodule

bind hs_split_unit hs_split_checker #(.CTRL_W(CTRL_W), .HL_W(HL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .rx_ctrl    (rx_ctrl),
  .out_valid  (out_valid),
  .split_en   (split_en),
  .hdr_bytes  (hdr_bytes),
  .wb_hdr_len (wb_hdr_len),
  .wb_sph     (wb_sph),
  .wb_hbo     (wb_hbo)
);

// File: tb/tb_hs_split_unit.sv
module tb_hs_split_unit;
  localparam int CTRL_W = 32;
  localparam int LEN_W  = 16;
  localparam int OFS_W  = 10;
  localparam int HL_W   = 10;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [15:0] len;
    logic        v4;
    logic        v6;
    logic        frag;
    logic [1:0]  kind;
    logic [9:0]  l4;
    logic [9:0]  l5;
    logic        dis;
    logic        e_split;
    logic [9:0]  e_hdr;
    logic [9:0]  e_wb;
    logic        e_sph;
    logic        e_hbo;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  // kind: 0 other, 1 TCP, 2 UDP, 3 SCTP; header buffer 128 unless noted
  localparam vec_t VECS [NV] = '{
    '{32'h0200_0200, 16'd300, 1'b1,1'b0,1'b0,2'd1,10'd34,10'd54,1'b0, 1'b0,10'd0,  10'd0,  1'b0,1'b0, 8'd3}, // R3 type1
    '{32'h0000_0200, 16'd300, 1'b1,1'b0,1'b0,2'd1,10'd34,10'd54,1'b0, 1'b0,10'd0,  10'd0,  1'b0,1'b0, 8'd3}, // R3 type0
    '{32'h0600_0200, 16'd300, 1'b1,1'b0,1'b0,2'd1,10'd34,10'd54,1'b0, 1'b0,10'd0,  10'd0,  1'b0,1'b0, 8'd3}, // R3 type3
    '{32'h0E00_0200, 16'd300, 1'b1,1'b0,1'b0,2'd1,10'd34,10'd54,1'b0, 1'b0,10'd0,  10'd0,  1'b0,1'b0, 8'd3}, // R3 type7
    '{32'h0400_0200, 16'd300, 1'b1,1'b0,1'b0,2'd1,10'd34,10'd54,1'b0, 1'b1,10'd54, 10'd54, 1'b1,1'b0, 8'd8}, // R8 TCP
    '{32'h0400_0200, 16'd300, 1'b0,1'b1,1'b0,2'd2,10'd54,10'd62,1'b0, 1'b1,10'd62, 10'd62, 1'b1,1'b0, 8'd8}, // R8 UDP v6
    '{32'h0400_0200, 16'd300, 1'b1,1'b0,1'b0,2'd3,10'd34,10'd46,1'b0, 1'b1,10'd34, 10'd34, 1'b1,1'b0, 8'd8}, // R8 SCTP
    '{32'h0400_0200, 16'd300, 1'b1,1'b0,1'b0,2'd0,10'd34,10'd40,1'b0, 1'b1,10'd34, 10'd34, 1'b1,1'b0, 8'd8}, // R8 other
    '{32'h0400_0200, 16'd300, 1'b1,1'b0,1'b1,2'd1,10'd34,10'd54,1'b0, 1'b1,10'd34, 10'd34, 1'b1,1'b0, 8'd7}, // R7 frag allowed
    '{32'h0400_0200, 16'd300, 1'b0,1'b1,1'b1,2'd2,10'd54,10'd62,1'b1, 1'b0,10'd0,  10'd128,1'b0,1'b0, 8'd7}, // R7 frag blocked
    '{32'h0A00_0200, 16'd1000,1'b1,1'b0,1'b1,2'd1,10'd34,10'd54,1'b1, 1'b1,10'd128,10'd128,1'b0,1'b0, 8'd10},// R10 always fallback
    '{32'h0400_0200, 16'd500, 1'b0,1'b0,1'b0,2'd1,10'd14,10'd34,1'b0, 1'b0,10'd0,  10'd128,1'b0,1'b0, 8'd6}, // R6 plain non-IP
    '{32'h0A00_0200, 16'd500, 1'b0,1'b0,1'b0,2'd1,10'd14,10'd34,1'b0, 1'b1,10'd128,10'd128,1'b0,1'b0, 8'd6}, // R6 always non-IP
    '{32'h0A00_0200, 16'd100, 1'b0,1'b0,1'b0,2'd0,10'd14,10'd14,1'b0, 1'b1,10'd100,10'd100,1'b0,1'b0, 8'd5}, // R5 short
    '{32'h0A00_0200, 16'd128, 1'b1,1'b0,1'b0,2'd1,10'd34,10'd54,1'b0, 1'b1,10'd128,10'd128,1'b0,1'b0, 8'd5}, // R5 len==buf
    '{32'h0A00_0200, 16'd129, 1'b1,1'b0,1'b0,2'd1,10'd34,10'd54,1'b0, 1'b1,10'd54, 10'd54, 1'b1,1'b0, 8'd5}, // R5 len>buf
    '{32'h0400_0100, 16'd300, 1'b1,1'b0,1'b0,2'd1,10'd34,10'd66,1'b0, 1'b0,10'd0,  10'd66, 1'b1,1'b1, 8'd9}, // R9 plain overflow
    '{32'h0A00_0100, 16'd1000,1'b1,1'b0,1'b0,2'd1,10'd34,10'd66,1'b0, 1'b1,10'd64, 10'd66, 1'b1,1'b1, 8'd9}, // R9 always overflow
    '{32'h0400_0100, 16'd300, 1'b1,1'b0,1'b0,2'd1,10'd34,10'd64,1'b0, 1'b1,10'd64, 10'd64, 1'b1,1'b0, 8'd9}, // R9 point==buf
    '{32'h0400_0F00, 16'd1500,1'b0,1'b1,1'b0,2'd1,10'd54,10'd900,1'b0,1'b1,10'd900,10'd900,1'b1,1'b0, 8'd4}, // R4 max field
    '{32'hF5FF_F2FF, 16'd300, 1'b1,1'b0,1'b0,2'd2,10'd34,10'd42,1'b0, 1'b1,10'd42, 10'd42, 1'b1,1'b0, 8'd4}, // R4 other bits set
    '{32'h0A00_0000, 16'd0,   1'b0,1'b0,1'b0,2'd0,10'd0, 10'd0, 1'b0, 1'b1,10'd0,  10'd0,  1'b0,1'b0, 8'd4}, // R4 zero buf
    '{32'h0400_0000, 16'd300, 1'b1,1'b0,1'b0,2'd1,10'd34,10'd54,1'b0, 1'b0,10'd0,  10'd54, 1'b1,1'b1, 8'd4}  // R4 zero buf overflow
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic [CTRL_W-1:0] rx_ctrl;
  logic [LEN_W-1:0]  frame_len;
  logic              has_ipv4, has_ipv6, is_frag, frag_split_dis;
  logic [1:0]        l4_kind;
  logic [OFS_W-1:0]  l4_ofs, l5_ofs;
  logic              out_valid, split_en, wb_sph, wb_hbo;
  logic [HL_W-1:0]   hdr_bytes, wb_hdr_len;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  hs_split_unit #(.CTRL_W(CTRL_W), .LEN_W(LEN_W), .OFS_W(OFS_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rx_ctrl(rx_ctrl),
    .frame_len(frame_len), .has_ipv4(has_ipv4), .has_ipv6(has_ipv6),
    .is_frag(is_frag), .l4_kind(l4_kind), .l4_ofs(l4_ofs), .l5_ofs(l5_ofs),
    .frag_split_dis(frag_split_dis), .out_valid(out_valid), .split_en(split_en),
    .hdr_bytes(hdr_bytes), .wb_hdr_len(wb_hdr_len), .wb_sph(wb_sph), .wb_hbo(wb_hbo)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    rx_ctrl = v.ctrl; frame_len = v.len; has_ipv4 = v.v4; has_ipv6 = v.v6;
    is_frag = v.frag; l4_kind = v.kind; l4_ofs = v.l4; l5_ofs = v.l5;
    frag_split_dis = v.dis;
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    chk("R2", {tag, " out_valid"}, int'(out_valid), 1);
    chk(tag, "split_en", int'(split_en), int'(v.e_split));
    chk(tag, "hdr_bytes", int'(hdr_bytes), int'(v.e_hdr));
    chk(tag, "wb_hdr_len", int'(wb_hdr_len), int'(v.e_wb));
    chk(tag, "wb_sph", int'(wb_sph), int'(v.e_sph));
    chk(tag, "wb_hbo", int'(wb_hbo), int'(v.e_hbo));
  endtask

  task automatic check_zero(input string tag);
    chk(tag, "out_valid", int'(out_valid), 0);
    chk(tag, "split_en", int'(split_en), 0);
    chk(tag, "hdr_bytes", int'(hdr_bytes), 0);
    chk(tag, "wb_hdr_len", int'(wb_hdr_len), 0);
    chk(tag, "wb_sph", int'(wb_sph), 0);
    chk(tag, "wb_hbo", int'(wb_hbo), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    check_zero("R1");          // R1 reset state
    rst = 1'b0;

    // Table walk, back-to-back requests
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      check_vec(VECS[i], $sformatf("R%0d", VECS[i].req));
    end

    // R2: idle cycle drops valid and holds the last result
    in_valid = 1'b0;
    drive(VECS[4]);
    @(negedge clk);
    chk("R2", "idle out_valid", int'(out_valid), 0);
    chk("R2", "idle hdr_bytes", int'(hdr_bytes), int'(VECS[NV-1].e_hdr));
    chk("R2", "idle wb_hdr_len", int'(wb_hdr_len), int'(VECS[NV-1].e_wb));
    chk("R2", "idle wb_hbo", int'(wb_hbo), int'(VECS[NV-1].e_hbo));

    // R2: single request after idle
    in_valid = 1'b1;
    @(negedge clk);
    check_vec(VECS[4], "R8");
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2", "single out_valid low", int'(out_valid), 0);
    chk("R2", "single split held", int'(split_en), 1);

    // R1: reset while a request is presented wins
    drive(VECS[17]);
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check_zero("R1");
    rst = 1'b0;
    @(negedge clk);
    check_vec(VECS[17], "R10");  // R10 always-mode overflow fallback after reset
    in_valid = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule